// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers every interrupt source of a small processor-based controller into one request line toward the core. When the core answers that request with its interrupt acknowledge, the block supplies an instruction byte on the data bus that sends the core to the service routine of the most urgent source. Two sources are internal: a pulse saying that an addressed module never returned its acknowledge, and a periodic mark tick that paces sampling and display work. Any number of external modules share one active-low, wired-OR request line.

During the acknowledge, a requesting external module answers with an acknowledge strobe and raises exactly one of four identity lines. The identity line gives the module's priority. A smaller priority number is more urgent. The missing-acknowledge source has priority 1, identity lines 0..3 map to priorities 2..5, and the mark tick has priority 6. If nothing answers inside a bounded response window and no internal source is pending, the block drives a default priority of 7, so the core never reads an undriven bus. Each internal event is held in a pending latch until its own vector is issued. The latches, together with the synchronized external request, can be read on a status port.

Top module: `irqVecCtrl`

## Requirements
- R1: After reset, `intReq`, `vectorEn`, `vectorByte` and `pendingStatus` are all zero.
- R2: A one-cycle pulse on `ackMissPulse` or `markPulse` sets its pending latch at the next clock edge. `pendingStatus` bit 0 shows the missing-acknowledge latch, bit 1 shows the mark latch, and bit 2 shows the synchronized external request (high when `extReqN` is low).
- R3: While no acknowledge cycle is in progress, `intReq` goes high one clock after any pending bit is set. A low on `extReqN` passes through a 2-stage synchronizer, so `intReq` rises on the third clock edge after `extReqN` falls and not before.
- R4: `intReq` is low whenever the vector is being driven. After `intAckIn` falls, `intReq` is evaluated again from the remaining pending sources on the second clock edge.
- R5: The vector byte is `{2'b11, prio[2:0], 3'b111}`, which is a restart-style instruction. It appears only while `vectorEn` is high, and `vectorByte` is 0 otherwise. `vectorEn` is high only while `intAckIn` is high.
- R6: An acknowledge strobe with exactly one identity line k high, sampled while the response window is open, resolves to priority 2+k. The vector is enabled after the edge that samples the strobe.
- R7: The lowest priority number wins. Missing-acknowledge (1) beats any external module (2..5), and any external module beats the mark tick (6).
- R8: If no valid response is sampled, the block resolves on the 4th clock edge (RESP_WINDOW) after the edge that first samples `intAckIn` high. It drives the best pending internal priority, or 7 if none is pending.
- R9: An acknowledge strobe with no identity line high, or with more than one identity line high, is ignored, and the window keeps running as if nothing had answered.
- R10: A pending internal latch is cleared only when its own priority is issued as the vector. A losing internal source stays pending and raises `intReq` again.
- R11: The vector byte stays stable for as long as `intAckIn` is held high. Dropping `intAckIn` removes the vector at once, and dropping it during the response window ends the cycle without clearing anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ackMissPulse | input | 1 | One-cycle pulse: an addressed module gave no acknowledge |
| markPulse | input | 1 | One-cycle periodic mark tick |
| extReqN | input | 1 | Shared active-low external request line (asynchronous) |
| modAckStrobe | input | 1 | External module response strobe during acknowledge |
| modIds | input | 4 | One-hot identity lines of the responding module |
| intAckIn | input | 1 | Interrupt acknowledge from the processor core |
| intReq | output | 1 | Interrupt request to the processor core |
| vectorByte | output | 8 | Vector instruction byte for the data bus |
| vectorEn | output | 1 | Data bus drive enable for `vectorByte` |
| pendingStatus | output | 3 | {ext request seen, mark pending, missing-ack pending} |

## Verification
The bench sweeps every combination of pending internal sources against every kind of external answer: none, each of the four identity lines, a two-hot answer and an empty answer. For each combination it computes the winning priority as a minimum over candidates. A design with a wrong comparison order, for example the mark tick beating an external module, would return the wrong vector. A design that clears the losing latch would lose a mark tick. The bench counts the clock edges to the vector, so a window that is one cycle short or long, or a two-hot answer that is accepted, shows up as a wrong arrival time or a wrong vector. It also checks the synchronizer latency of the shared request line, and checks that a cycle aborted mid-window leaves the pending latches intact.

// File: rtl/irqVecPkg.sv
package irqVecPkg;

  localparam int VEC_PRIO_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESP  = 2'd1,
    ST_DRIVE = 2'd2
  } ackState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;        // no acknowledge cycle in progress
    logic loadWinner;  // resolve priority this cycle
    logic useExt;      // external answer takes part in resolution
    logic drive;       // vector phase
  } ctrlStrobe_t;

  function automatic logic [7:0] restartByte(input logic [VEC_PRIO_W-1:0] prio);
    return {2'b11, prio, 3'b111};
  endfunction

endpackage

// File: rtl/irqVecCtrl_control.sv
module irqVecCtrl_control
  import irqVecPkg::*;
#(
  parameter int RESP_WINDOW = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        intAckIn,
  input  logic        idValid,
  output ctrlStrobe_t strobes
);

  localparam int CNT_W = (RESP_WINDOW < 2) ? 1 : $clog2(RESP_WINDOW);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RESP_WINDOW - 1);

  ackState_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    stateD             = stateQ;
    cntD               = cntQ;
    strobes.idle       = (stateQ == ST_IDLE);
    strobes.drive      = (stateQ == ST_DRIVE);
    strobes.loadWinner = 1'b0;
    strobes.useExt     = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (intAckIn) begin
          stateD = ST_RESP;
          cntD   = '0;
        end
      end
      ST_RESP: begin
        if (!intAckIn) begin
          stateD = ST_IDLE;
        end else if (idValid) begin
          strobes.loadWinner = 1'b1;
          strobes.useExt     = 1'b1;
          stateD             = ST_DRIVE;
        end else if (cntQ == LAST_CNT) begin
          strobes.loadWinner = 1'b1;
          stateD             = ST_DRIVE;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_DRIVE: begin
        if (!intAckIn) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RESP) |-> (cntQ <= LAST_CNT)); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RESP && !intAckIn) |=> (stateQ == ST_IDLE)); // R11
  AST_ANSWER_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RESP && intAckIn && idValid) |=> (stateQ == ST_DRIVE)); // R6

endmodule

// File: rtl/irqVecCtrl_datapath.sv
module irqVecCtrl_datapath
  import irqVecPkg::*;
#(
  parameter int NUM_IDS      = 4,
  parameter int ID_BASE_PRIO = 2,
  parameter int ACK_PRIO     = 1,
  parameter int MARK_PRIO    = 6,
  parameter int DEFAULT_PRIO = 7,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ackMissPulse,
  input  logic               markPulse,
  input  logic               extReqN,
  input  logic               modAckStrobe,
  input  logic [NUM_IDS-1:0] modIds,
  input  logic               intAckIn,
  input  ctrlStrobe_t        strobes,
  output logic               idValid,
  output logic [2:0]         pendingStatus,
  output logic               intReq,
  output logic [7:0]         vectorByte,
  output logic               vectorEn
);

  localparam int PW = VEC_PRIO_W;
  localparam logic [PW-1:0] P_ACK  = PW'(ACK_PRIO);
  localparam logic [PW-1:0] P_MARK = PW'(MARK_PRIO);
  localparam logic [PW-1:0] P_DEF  = PW'(DEFAULT_PRIO);

  // synchronizer for the asynchronous shared request line
  logic [SYNC_STAGES-1:0] syncQ;
  logic extSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], ~extReqN};
  end
  assign extSeen = syncQ[SYNC_STAGES-1];

  // identity line decode
  logic [PW-1:0] linePrio [NUM_IDS];
  logic [PW-1:0] extPrio;

  for (genvar g = 0; g < NUM_IDS; g++) begin : gLine
    assign linePrio[g] = modIds[g] ? PW'(ID_BASE_PRIO + g) : P_DEF;
  end

  always_comb begin
    extPrio = P_DEF;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (linePrio[i] < extPrio) extPrio = linePrio[i];
    end
  end

  assign idValid = modAckStrobe && $onehot(modIds);

  // pending latches and resolution
  logic pendAck, pendMark;
  logic clrAck, clrMark;
  logic [PW-1:0] winnerD, winPrio;
  logic intReqQ;

  always_comb begin
    winnerD = P_DEF;
    if (pendMark && P_MARK < winnerD) winnerD = P_MARK;
    if (pendAck && P_ACK < winnerD) winnerD = P_ACK;
    if (strobes.useExt && extPrio < winnerD) winnerD = extPrio;
  end

  assign clrAck  = strobes.loadWinner && pendAck  && (winnerD == P_ACK);
  assign clrMark = strobes.loadWinner && pendMark && (winnerD == P_MARK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAck  <= 1'b0;
      pendMark <= 1'b0;
      winPrio  <= P_DEF;
      intReqQ  <= 1'b0;
    end else begin
      pendAck  <= ackMissPulse | (pendAck  & ~clrAck);
      pendMark <= markPulse    | (pendMark & ~clrMark);
      if (strobes.loadWinner) winPrio <= winnerD;
      intReqQ  <= strobes.idle & (pendAck | pendMark | extSeen);
    end
  end

  assign intReq        = intReqQ;
  assign pendingStatus = {extSeen, pendMark, pendAck};
  assign vectorEn      = strobes.drive & intAckIn;
  assign vectorByte    = vectorEn ? restartByte(winPrio) : 8'h00;

  AST_NO_REQ_IN_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    vectorEn |-> !intReq); // R4
  AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (vectorEn && $past(vectorEn)) |-> $stable(vectorByte)); // R11
  AST_ACK_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadWinner && pendAck) |=> (winPrio == P_ACK)); // R7
  AST_MARK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pendMark && !strobes.loadWinner) |=> pendMark); // R10
  AST_EXT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.useExt && !pendAck) |=>
      (winPrio >= PW'(ID_BASE_PRIO) && winPrio < PW'(ID_BASE_PRIO + NUM_IDS))); // R6
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !vectorEn |-> (vectorByte == 8'h00)); // R5

endmodule

// File: rtl/irqVecCtrl.sv
module irqVecCtrl
  import irqVecPkg::*;
#(
  parameter int NUM_IDS      = 4,
  parameter int ID_BASE_PRIO = 2,
  parameter int ACK_PRIO     = 1,
  parameter int MARK_PRIO    = 6,
  parameter int DEFAULT_PRIO = 7,
  parameter int SYNC_STAGES  = 2,
  parameter int RESP_WINDOW  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ackMissPulse,
  input  logic               markPulse,
  input  logic               extReqN,
  input  logic               modAckStrobe,
  input  logic [NUM_IDS-1:0] modIds,
  input  logic               intAckIn,
  output logic               intReq,
  output logic [7:0]         vectorByte,
  output logic               vectorEn,
  output logic [2:0]         pendingStatus
);

  ctrlStrobe_t strobes;
  logic idValid;

  irqVecCtrl_control #(
    .RESP_WINDOW(RESP_WINDOW)
  ) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .intAckIn (intAckIn),
    .idValid  (idValid),
    .strobes  (strobes)
  );

  irqVecCtrl_datapath #(
    .NUM_IDS      (NUM_IDS),
    .ID_BASE_PRIO (ID_BASE_PRIO),
    .ACK_PRIO     (ACK_PRIO),
    .MARK_PRIO    (MARK_PRIO),
    .DEFAULT_PRIO (DEFAULT_PRIO),
    .SYNC_STAGES  (SYNC_STAGES)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .ackMissPulse  (ackMissPulse),
    .markPulse     (markPulse),
    .extReqN       (extReqN),
    .modAckStrobe  (modAckStrobe),
    .modIds        (modIds),
    .intAckIn      (intAckIn),
    .strobes       (strobes),
    .idValid       (idValid),
    .pendingStatus (pendingStatus),
    .intReq        (intReq),
    .vectorByte    (vectorByte),
    .vectorEn      (vectorEn)
  );

endmodule

// File: tb/test_irqVecCtrl.sv
module test_irqVecCtrl;

  localparam int WIN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ackMissPulse = 1'b0, markPulse = 1'b0, extReqN = 1'b1;
  logic modAckStrobe = 1'b0, intAckIn = 1'b0;
  logic [3:0] modIds = 4'b0;
  logic intReq, vectorEn;
  logic [7:0] vectorByte;
  logic [2:0] pendingStatus;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  irqVecCtrl i_irqVecCtrl (
    .clk(clk), .rstN(rstN), .ackMissPulse(ackMissPulse), .markPulse(markPulse),
    .extReqN(extReqN), .modAckStrobe(modAckStrobe), .modIds(modIds),
    .intAckIn(intAckIn), .intReq(intReq), .vectorByte(vectorByte),
    .vectorEn(vectorEn), .pendingStatus(pendingStatus)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int vecOf(input int p);
    return 8'hC7 | (p << 3);
  endfunction

  task automatic doReset();
    ackMissPulse = 0; markPulse = 0; extReqN = 1; modAckStrobe = 0;
    modIds = 0; intAckIn = 0;
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected <100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk); @(negedge clk);
    check(intReq == 0 && vectorEn == 0, "R1", {intReq, vectorEn}, 0);
    check(vectorByte == 0 && pendingStatus == 0, "R1", {vectorByte, pendingStatus}, 0);
    rstN = 1; @(negedge clk);

    // R3 external request synchronizer latency
    extReqN = 0;
    @(negedge clk); check(intReq == 0, "R3 edge1", intReq, 0);
    @(negedge clk); check(intReq == 0, "R3 edge2", intReq, 0);
    check(pendingStatus == 3'b100, "R2 ext bit", pendingStatus, 3'b100);
    @(negedge clk); check(intReq == 1, "R3 edge3", intReq, 1);
    doReset();

    // R11 abort mid-window keeps pending
    markPulse = 1; @(negedge clk); markPulse = 0;
    intAckIn = 1; @(negedge clk); @(negedge clk);
    intAckIn = 0; @(negedge clk); @(negedge clk); @(negedge clk);
    check(pendingStatus == 3'b010, "R11 abort keeps latch", pendingStatus, 3'b010);
    check(vectorEn == 0, "R11 no vector after abort", vectorEn, 0);
    doReset();

    // near-exhaustive sweep: internal pending x external answer
    // ans: 0 none, 1..4 id line ans-1, 5 two-hot, 6 empty strobe
    for (int pend = 0; pend < 4; pend++) begin
      for (int ans = 0; ans < 7; ans++) begin
        int expPrio, k, expK, remain;
        bit extValid;
        doReset();
        ackMissPulse = pend[0]; markPulse = pend[1];
        @(negedge clk);
        ackMissPulse = 0; markPulse = 0;
        check(pendingStatus == 3'(pend), "R2 latch", pendingStatus, pend);
        @(negedge clk);
        if (pend != 0) check(intReq == 1, "R3 internal", intReq, 1);
        extValid = (ans >= 1 && ans <= 4);
        expPrio = 7;
        if (pend[1]) expPrio = 6;
        if (extValid && (ans + 1) < expPrio) expPrio = ans + 1;
        if (pend[0]) expPrio = 1;
        expK = extValid ? 2 : WIN + 1;
        intAckIn = 1;
        k = 0;
        while (!vectorEn && k < 20) begin
          @(negedge clk); k++;
          if (k == 1 && ans != 0) begin
            modAckStrobe = 1;
            modIds = (ans <= 4) ? 4'(1 << (ans - 1)) : (ans == 5 ? 4'b0110 : 4'b0000);
          end else begin
            modAckStrobe = 0; modIds = 0;
          end
        end
        modAckStrobe = 0; modIds = 0;
        if (extValid) check(k == expK, "R6 answer timing", k, expK);
        else check(k == expK, (ans == 0) ? "R8 window timing" : "R9 bad id ignored", k, expK);
        check(vectorByte == 8'(vecOf(expPrio)), (extValid && !pend[0]) ? "R6 R7 vector" : "R7 R8 vector",
              vectorByte, vecOf(expPrio));
        check(intReq == 0, "R4 low in drive", intReq, 0);
        @(negedge clk); @(negedge clk);
        check(vectorEn == 1 && vectorByte == 8'(vecOf(expPrio)), "R11 stable", vectorByte, vecOf(expPrio));
        intAckIn = 0; #1;
        check(vectorEn == 0 && vectorByte == 0, "R5 drop with ack", {vectorEn, vectorByte}, 0);
        @(negedge clk); @(negedge clk);
        remain = pend;
        if (expPrio == 1) remain = remain & 2;
        if (expPrio == 6) remain = remain & 1;
        check(pendingStatus[1:0] == 2'(remain), "R10 clear own only", pendingStatus[1:0], remain);
        check(intReq == (remain != 0), "R4 re-evaluate", intReq, remain != 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule